// File: doc/BRIEF.md
# Line-Stride and Page-Fragment Read Request Generator

This block turns the geometry fields of an already validated DMA descriptor into a sequence of read requests. Each request is an address and a byte length, offered to a memory read master over a valid/ready handshake. The block does not move data and does not parse descriptors beyond the fields it is given.

The block has two walk modes.

- **Line walk:** the block reads fixed-size lines. Consecutive lines are separated by a programmable stride, and the walk ends when the total byte count is used up.
- **Page walk:** the block visits up to five independent source bases. Each request ends at the next 4096-byte page edge, or earlier if fewer bytes remain.

A read-error response from the master aborts the walk. Two degenerate set-ups end at once without issuing any request: a zero total, and a zero line size in line walk.

Top module: `stride_frag_addr_gen`

## Requirements
- R1: After reset, `req_valid`, `done`, `size_err`, `data_err` and `busy` are all low.
- R2: The packed line word carries the line size in bits [17:0] and a stride count in bits [31:18]. The stride in bytes is that count times 16.
- R3: Line walk is selected with `frag_mode`=0. The first request starts at fragment base 0. Each later request starts one stride above the previous one. Every request is line-size bytes long, except the final one, which is cut to the bytes still owed. Requests continue until `xfer_size` bytes are requested.
- R4: Page walk is selected with `frag_mode`=1. Request k starts at fragment base k (base k sits in `frag_base_flat` bits [48k+47:48k]). Its length is 4096 minus (address mod 4096), cut to the bytes still owed.
- R5: Page walk stops after five requests even if bytes remain. It also stops as soon as the bytes still owed reach zero.
- R6: An offered request keeps `req_valid`, `req_addr` and `req_len` unchanged until `req_ready` is high at a clock edge. The next request appears in the cycle right after that acceptance.
- R7: `done` is high for exactly the one cycle that follows the acceptance of the last request.
- R8: A start with `xfer_size`=0 issues no request. It raises `done` in the cycle after the start, with `size_err` low.
- R9: A start in line walk with a zero line size and a nonzero total issues no request. It raises `done` and `size_err` together in the cycle after the start.
- R10: `rd_err` high at an edge while busy ends the walk. `data_err` pulses in the next cycle, no further request is offered, and `done` stays low.
- R11: `start` is ignored while a walk is in progress. The offered request and the rest of the sequence are unchanged.
- R12: The first request is offered in the cycle after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk with the current set-up inputs |
| xfer_size | input | 32 | Total bytes to request |
| line_word | input | 32 | Packed line size [17:0] and stride count [31:18] |
| frag_mode | input | 1 | 0 = line walk, 1 = page walk |
| frag_base_flat | input | 240 | Five 48-bit source bases. They must stay stable during a walk |
| rd_err | input | 1 | Read-error response from the master |
| req_valid | output | 1 | A request is offered |
| req_ready | input | 1 | The master accepts the offered request |
| req_addr | output | 48 | Request start address |
| req_len | output | 32 | Request byte length |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse at the end of a walk |
| size_err | output | 1 | One-cycle pulse for a zero line size in line walk |
| data_err | output | 1 | One-cycle pulse after a read error aborts a walk |

## Verification
Each result has a fixed cycle in which it is due:

- **First request:** due one edge after `start`.
- **Next request:** visible one edge after each acceptance.
- **End pulses:** `done`, `size_err` and `data_err` fall in the single cycle that follows their cause.

The bench drives inputs on falling edges and samples on the falling edge that follows the edge which should produce each result. It then checks that the pulse is gone one falling edge later. The expected address/length sequences come from a separate walk model in the bench. Stall cycles are inserted to confirm that the offered request holds steady while `req_ready` is low.

// File: rtl/sfag_pkg.sv
package sfag_pkg;
  localparam int LINE_WORD_W    = 32;
  localparam int LINE_LEN_W     = 18;
  localparam int STRIDE_FIELD_W = LINE_WORD_W - LINE_LEN_W;
  localparam int STRIDE_UNIT_LG = 4;
  localparam int STRIDE_W       = STRIDE_FIELD_W + STRIDE_UNIT_LG;

  typedef enum logic {
    WALK_LINES = 1'b0,
    WALK_PAGES = 1'b1
  } walk_mode_e;

  function automatic logic [LINE_LEN_W-1:0] line_bytes(input logic [LINE_WORD_W-1:0] w);
    return w[LINE_LEN_W-1:0];
  endfunction

  function automatic logic [STRIDE_W-1:0] stride_bytes(input logic [LINE_WORD_W-1:0] w);
    return {w[LINE_WORD_W-1:LINE_LEN_W], {STRIDE_UNIT_LG{1'b0}}};
  endfunction
endpackage

// File: rtl/sfag_frag_sel.sv
module sfag_frag_sel #(
  parameter int N_FRAG = 5,
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 3
) (
  input  logic [N_FRAG*ADDR_W-1:0] flat,
  input  logic [IDX_W-1:0]         idx,
  output logic [ADDR_W-1:0]        base
);
  logic [ADDR_W-1:0] slots [N_FRAG];

  generate
    for (genvar g = 0; g < N_FRAG; g++) begin : g_slot
      assign slots[g] = flat[g*ADDR_W +: ADDR_W];
    end
  endgenerate

  always_comb begin
    base = '0;
    for (int i = 0; i < N_FRAG; i++) begin
      if (idx == IDX_W'(i)) base = slots[i];
    end
  end
endmodule

// File: rtl/sfag_step_calc.sv
module sfag_step_calc
  import sfag_pkg::*;
#(
  parameter int LEN_W   = 32,
  parameter int PAGE_LG = 12,
  parameter int N_FRAG  = 5,
  parameter int IDX_W   = 3
) (
  input  walk_mode_e            mode,
  input  logic [PAGE_LG-1:0]    page_off,
  input  logic [LEN_W-1:0]      remaining,
  input  logic [LINE_LEN_W-1:0] line_len,
  input  logic [IDX_W-1:0]      frag_idx,
  output logic [LEN_W-1:0]      step_len,
  output logic [LEN_W-1:0]      rem_after,
  output logic                  is_last
);
  localparam logic [LEN_W-1:0] PAGE_BYTES = LEN_W'(1) << PAGE_LG;

  function automatic logic [LEN_W-1:0] page_room(input logic [PAGE_LG-1:0] off);
    return PAGE_BYTES - LEN_W'(off);
  endfunction

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] want,
                                                 input logic [LEN_W-1:0] left);
    return (want < left) ? want : left;
  endfunction

  logic [LEN_W-1:0] raw_len;

  always_comb begin
    raw_len   = (mode == WALK_PAGES) ? page_room(page_off) : LEN_W'(line_len);
    step_len  = clamp_len(raw_len, remaining);
    rem_after = remaining - step_len;
    is_last   = (rem_after == '0) ||
                ((mode == WALK_PAGES) && (frag_idx == IDX_W'(N_FRAG - 1)));
  end
endmodule

// File: rtl/stride_frag_addr_gen.sv
module stride_frag_addr_gen
  import sfag_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 32,
  parameter int N_FRAG  = 5,
  parameter int PAGE_LG = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LEN_W-1:0]         xfer_size,
  input  logic [LINE_WORD_W-1:0]   line_word,
  input  logic                     frag_mode,
  input  logic [N_FRAG*ADDR_W-1:0] frag_base_flat,
  input  logic                     rd_err,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [ADDR_W-1:0]        req_addr,
  output logic [LEN_W-1:0]         req_len,
  output logic                     busy,
  output logic                     done,
  output logic                     size_err,
  output logic                     data_err
);
  localparam int IDX_W = $clog2(N_FRAG + 1);
  localparam logic [LEN_W:0] PAGE_BYTES_X = (LEN_W+1)'(1) << PAGE_LG;

  walk_mode_e            mode_q;
  logic [ADDR_W-1:0]     cur_addr_q;
  logic [LEN_W-1:0]      rem_q;
  logic [IDX_W-1:0]      fidx_q;
  logic [LINE_LEN_W-1:0] line_q;
  logic [STRIDE_W-1:0]   stride_q;
  logic                  busy_q, done_q, serr_q, derr_q;

  // Named events, used both by the logic and by the assertions
  logic                  start_ok, accept_w, abort_w;
  logic [LEN_W-1:0]      step_len_w, rem_after_w;
  logic                  last_w;
  logic [IDX_W-1:0]      sel_idx_w;
  logic [ADDR_W-1:0]     sel_base_w;
  logic [LINE_LEN_W-1:0] line_in_w;

  assign start_ok  = start && !busy_q;
  assign abort_w   = busy_q && rd_err;
  assign accept_w  = busy_q && req_ready && !rd_err;
  assign sel_idx_w = busy_q ? (fidx_q + IDX_W'(1)) : '0;
  assign line_in_w = line_bytes(line_word);

  sfag_frag_sel #(.N_FRAG(N_FRAG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_sel (
    .flat (frag_base_flat),
    .idx  (sel_idx_w),
    .base (sel_base_w)
  );

  sfag_step_calc #(.LEN_W(LEN_W), .PAGE_LG(PAGE_LG), .N_FRAG(N_FRAG), .IDX_W(IDX_W)) u_calc (
    .mode      (mode_q),
    .page_off  (cur_addr_q[PAGE_LG-1:0]),
    .remaining (rem_q),
    .line_len  (line_q),
    .frag_idx  (fidx_q),
    .step_len  (step_len_w),
    .rem_after (rem_after_w),
    .is_last   (last_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= WALK_LINES;
      cur_addr_q <= '0;
      rem_q      <= '0;
      fidx_q     <= '0;
      line_q     <= '0;
      stride_q   <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      serr_q     <= 1'b0;
      derr_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      serr_q <= 1'b0;
      derr_q <= 1'b0;
      if (start_ok) begin
        mode_q     <= walk_mode_e'(frag_mode);
        line_q     <= line_in_w;
        stride_q   <= stride_bytes(line_word);
        rem_q      <= xfer_size;
        fidx_q     <= '0;
        cur_addr_q <= sel_base_w;
        if (xfer_size == '0) begin
          done_q <= 1'b1;
        end else if (!frag_mode && (line_in_w == '0)) begin
          done_q <= 1'b1;
          serr_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
        end
      end else if (abort_w) begin
        busy_q <= 1'b0;
        derr_q <= 1'b1;
      end else if (accept_w) begin
        rem_q <= rem_after_w;
        if (mode_q == WALK_PAGES) begin
          fidx_q     <= fidx_q + IDX_W'(1);
          cur_addr_q <= sel_base_w;
        end else begin
          cur_addr_q <= cur_addr_q + ADDR_W'(stride_q);
        end
        if (last_w) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign req_valid = busy_q;
  assign req_addr  = cur_addr_q;
  assign req_len   = step_len_w;
  assign busy      = busy_q;
  assign done      = done_q;
  assign size_err  = serr_q;
  assign data_err  = derr_q;

  // Assertions next to the logic they guard
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !rd_err) |=> (req_valid && $stable(req_addr) && $stable(req_len)));

  assert_len_in_budget_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len <= rem_q) && (req_len != '0));

  assert_page_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_q == WALK_PAGES) |->
      ((LEN_W+1)'(req_addr[PAGE_LG-1:0]) + (LEN_W+1)'(req_len) <= PAGE_BYTES_X));

  assert_stride_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_w && !last_w && mode_q == WALK_LINES) |=>
      (req_valid && req_addr == $past(req_addr) + ADDR_W'($past(stride_q))));

  assert_frag_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (fidx_q < IDX_W'(N_FRAG)));

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start_ok || (accept_w && last_w)));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (data_err && !req_valid && !done));

  assert_size_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> (done && !req_valid));
endmodule

// File: tb/sim_stride_frag_addr_gen.sv
`timescale 1ns/1ps
module sim_stride_frag_addr_gen;
  localparam int AW = 48;
  localparam int LW = 32;
  localparam int NF = 5;

  typedef struct packed {
    logic          mode;
    logic [31:0]   xfer;
    logic [31:0]   lword;
    logic [AW-1:0] b0, b1, b2, b3, b4;
    logic          stall;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd256,   (32'd8 << 18) | 32'd64,   48'h0000_1000_0000, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0},
    '{1'b0, 32'd100,   (32'd3 << 18) | 32'd32,   48'h00AB_0000_0010, 48'h0, 48'h0, 48'h0, 48'h0, 1'b1},
    '{1'b1, 32'd10000, 32'd0, 48'h0000_2000_0F00, 48'h0000_3000_0000, 48'h0000_4000_0800,
                              48'h0000_5000_0000, 48'h0000_6000_0000, 1'b1},
    '{1'b1, 32'd30000, 32'd0, 48'h0001_0000_0004, 48'h0002_0000_0100, 48'h0003_0000_0000,
                              48'h0004_0000_0FFF, 48'h0005_0000_0200, 1'b0},
    '{1'b1, 32'd100,   32'd0, 48'h0000_0000_0FF0, 48'h0000_0000_8000, 48'h0, 48'h0, 48'h0, 1'b0},
    '{1'b0, 32'd8192,  32'd4096, 48'h0000_0000_9000, 48'h0, 48'h0, 48'h0, 48'h0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] xfer_size = '0;
  logic [31:0] line_word = '0;
  logic frag_mode = 1'b0;
  logic [NF*AW-1:0] frag_base_flat = '0;
  logic rd_err = 1'b0;
  logic req_ready = 1'b0;
  logic req_valid, busy, done, size_err, data_err;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  stride_frag_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_size(xfer_size),
    .line_word(line_word), .frag_mode(frag_mode), .frag_base_flat(frag_base_flat),
    .rd_err(rd_err), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
    .size_err(size_err), .data_err(data_err)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  // Bench model: the expected request list, derived from the requirements
  longint ex_a [8];
  longint ex_l [8];
  int     ex_n;

  task automatic model(input vec_t v);
    longint rem, a, room, l;
    longint b [NF];
    b[0] = v.b0; b[1] = v.b1; b[2] = v.b2; b[3] = v.b3; b[4] = v.b4;
    rem = v.xfer;
    ex_n = 0;
    if (!v.mode) begin
      a = b[0];
      while (rem > 0) begin
        l = (v.lword % 262144 < rem) ? v.lword % 262144 : rem;
        ex_a[ex_n] = a; ex_l[ex_n] = l; ex_n++;
        rem -= l;
        a += (v.lword / 262144) * 16;
      end
    end else begin
      for (int k = 0; k < NF && rem > 0; k++) begin
        room = 4096 - (b[k] % 4096);
        l = (room < rem) ? room : rem;
        ex_a[k] = b[k]; ex_l[k] = l; ex_n++;
        rem -= l;
      end
    end
  endtask

  task automatic load(input vec_t v);
    xfer_size = v.xfer;
    line_word = v.lword;
    frag_mode = v.mode;
    frag_base_flat = {v.b4, v.b3, v.b2, v.b1, v.b0};
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    model(v);
    load(v);
    pulse_start();
    for (int k = 0; k < ex_n; k++) begin
      chk(req, "valid", longint'(req_valid), 1);
      chk(req, "addr", longint'(req_addr), ex_a[k]);
      chk(req, "len", longint'(req_len), ex_l[k]);
      if (v.stall && (k % 2 == 0)) begin
        @(negedge clk);
        chk("R6", "hold valid", longint'(req_valid), 1);
        chk("R6", "hold addr", longint'(req_addr), ex_a[k]);
        chk("R6", "hold len", longint'(req_len), ex_l[k]);
      end
      req_ready = 1'b1;
      @(negedge clk);
      req_ready = 1'b0;
      if (k == ex_n - 1) begin
        chk("R7", "done after last", longint'(done), 1);
        chk("R7", "valid after last", longint'(req_valid), 0);
        @(negedge clk);
        chk("R7", "done one cycle", longint'(done), 0);
      end else begin
        chk("R7", "no early done", longint'(done), 0);
      end
    end
  endtask

  initial begin
    #1;
    // R1: reset state
    chk("R1", "valid", longint'(req_valid), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "size_err", longint'(size_err), 0);
    chk("R1", "data_err", longint'(data_err), 0);
    chk("R1", "busy", longint'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2 R3 R4 R5 R6 R12
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], VECS[i].mode ? "R4/R5/R12" : "R2/R3/R12");
      @(negedge clk);
    end

    // R8: zero total
    load('{1'b0, 32'd0, 32'd64, 48'h100, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0});
    pulse_start();
    chk("R8", "done", longint'(done), 1);
    chk("R8", "valid", longint'(req_valid), 0);
    chk("R8", "size_err", longint'(size_err), 0);
    @(negedge clk);
    chk("R8", "done gone", longint'(done), 0);

    // R9: zero line size, nonzero total
    load('{1'b0, 32'd64, (32'd2 << 18), 48'h100, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0});
    pulse_start();
    chk("R9", "done", longint'(done), 1);
    chk("R9", "size_err", longint'(size_err), 1);
    chk("R9", "valid", longint'(req_valid), 0);
    @(negedge clk);
    chk("R9", "size_err gone", longint'(size_err), 0);

    // R10: read error aborts
    load('{1'b0, 32'd256, (32'd4 << 18) | 32'd64, 48'h5000, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0});
    pulse_start();
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R10", "second addr", longint'(req_addr), 64'h5040);
    rd_err = 1'b1;
    @(negedge clk);
    rd_err = 1'b0;
    chk("R10", "data_err", longint'(data_err), 1);
    chk("R10", "valid", longint'(req_valid), 0);
    chk("R10", "done", longint'(done), 0);
    @(negedge clk);
    chk("R10", "data_err gone", longint'(data_err), 0);
    chk("R10", "still idle", longint'(req_valid), 0);

    // R11: start ignored while busy
    load('{1'b0, 32'd128, (32'd4 << 18) | 32'd64, 48'h7000, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0});
    pulse_start();
    chk("R11", "first addr", longint'(req_addr), 64'h7000);
    load('{1'b1, 32'd0, 32'd0, 48'h9999, 48'h0, 48'h0, 48'h0, 48'h0, 1'b0});
    pulse_start();
    chk("R11", "addr kept", longint'(req_addr), 64'h7000);
    chk("R11", "len kept", longint'(req_len), 64);
    chk("R11", "no done", longint'(done), 0);
    req_ready = 1'b1;
    @(negedge clk);
    chk("R11", "next addr", longint'(req_addr), 64'h7040);
    chk("R11", "next len", longint'(req_len), 64);
    @(negedge clk);
    req_ready = 1'b0;
    chk("R11", "done", longint'(done), 1);
    @(negedge clk);
    finish_up();
  end
endmodule